// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is the write-only control port of a six-channel audio converter. A host drives three lines: a serial clock, a mode line and a data line. The block samples all three into the system clock domain. It assembles bytes least significant bit first, one bit on each rising edge of the serial clock. A byte sent while the mode line is low is an address byte. It selects this device, which answers to one of two addresses picked by a strap pin, and it picks one of two register banks. Bytes sent while the mode line is high are data bytes. They are written into the selected bank until the next address byte.

The status bank holds the clock-ratio code, the input-format code, the mute type and the power bit, plus a self-clearing reset command. The data bank holds a 6-bit volume, a 2-bit sub-volume, a mute bit, a polarity bit and a silence-participation bit for each channel. It also holds a global de-emphasis code and a sticky channel pointer. The pointer sends later feature writes either to one channel or to all six at once.

Top module: `ctl3w_ctrl`

## Requirements
- R1: Each bit is taken from the data line at a rising serial-clock edge. Bits arrive least significant first. A byte takes effect only after its eighth bit, a few system clocks later.
- R2: An address byte selects the device when bits 7:2 equal 00010 followed by the strap pin. Bits 1:0 then pick the bank: 00 selects the data bank and 10 selects the status bank.
- R3: An address byte with any other device field, or with a type code of 01 or 11, deselects the block. Data bytes that follow it change no output.
- R4: A selection stays in force for any number of following data bytes, until the next address byte.
- R5: A change on the mode line discards a byte that is partly received. Counting restarts at the next bit.
- R6: Status byte with bit 7 = 0: bits 4:3 give the clock-ratio code and bits 2:0 give the input-format code. Status byte with bits 7:6 = 10: bit 1 gives quick mute and bit 0 gives power. Status bits 7:6 = 11 is ignored.
- R7: A status byte with bit 7 = 0 and bit 5 = 1 sets defaults on every channel and on the global fields: all volumes and sub-volumes 0, mute 0, polarity 0, silence participation 1, de-emphasis 0, quick mute 0, power 1. Clock ratio and format take that byte's bits 4:3 and 2:0.
- R8: Data byte with bits 7:6 = 11 loads the channel pointer: bit 3 is the all-channels flag and bits 2:0 are the channel code. Codes 0 to 5 address channels 1 to 6. With the flag at 0, a volume write (bits 7:6 = 00, value in bits 5:0) or a feature write (bits 7:6 = 10: bit 2 mute, bit 1 silence participation, bit 0 polarity) reaches only the pointed channel.
- R9: With the all-channels flag at 1, volume, sub-volume and feature writes update all six channels.
- R10: With the flag at 0 and channel code 6 or 7, volume, sub-volume and feature writes change nothing.
- R11: A sub-volume write (bits 7:6 = 01, value in bits 1:0) is held in a staging register. The sub-volume output of a channel changes only when that channel's volume is written later.
- R12: De-emphasis (feature byte bits 5:3) is one global field. It is loaded only by feature writes made while the all-channels flag is 1.
- R13: After hardware reset the block is deselected and the pointer is set to all channels. Volumes, sub-volumes, mute, polarity, de-emphasis, clock ratio, format and quick mute read 0. Power and silence participation read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_mode_i | input | 1 | Mode line: low for an address byte, high for a data byte |
| ser_dat_i | input | 1 | Serial data, least significant bit first |
| addr_strap_i | input | 1 | Strap that sets the lowest device-address bit |
| vol_o | output | NCH*6 | Volume per channel; channel c at bits 6c+5:6c |
| subvol_o | output | NCH*2 | Sub-volume per channel; channel c at bits 2c+1:2c |
| mute_o | output | NCH | Mute per channel |
| invert_o | output | NCH | Output polarity inversion per channel |
| silence_en_o | output | NCH | Silence-detection participation per channel |
| deemph_o | output | 3 | Global de-emphasis code |
| clk_ratio_o | output | 2 | System-clock ratio code |
| in_fmt_o | output | 3 | Serial audio input format code |
| quick_mute_o | output | 1 | 1 selects quick mute, 0 selects soft mute |
| power_on_o | output | 1 | 1 powers the channels |

## Verification
The bench points the channel pointer at each channel in turn and writes distinct volumes. A decoder that ignored the pointer or mis-indexed the channel would spread each value to the wrong slot. It sweeps every clock-ratio and format code, and it issues the reset command. A reset that also cleared the clock ratio and format would show up there. It writes through channel codes 6 and 7 and through deselecting addresses for both strap values. A decoder that aliased these onto real channels or accepted a foreign address would alter outputs. It also checks three more cases. A partial byte is cut off by the mode line: a design that kept counting would shift the next byte. A sub-volume must wait for its volume write: an eager design would change the output early. De-emphasis is written with the flag clear: a design that accepted it would change the global code.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int VOL_W = 6;
  localparam int SUB_W = 2;
  localparam int DE_W  = 3;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_DATA = 2'd1,
    BANK_STAT = 2'd2
  } bank_e;

  localparam logic [1:0] XFER_DATA = 2'b00;
  localparam logic [1:0] XFER_STAT = 2'b10;

  localparam logic [1:0] SEL_VOL  = 2'b00;
  localparam logic [1:0] SEL_SUB  = 2'b01;
  localparam logic [1:0] SEL_FEAT = 2'b10;
  localparam logic [1:0] SEL_CHAN = 2'b11;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       mode_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       byte_addr_o
);
  logic [2:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] byte_q, byte_d;
  logic       vld_q, vld_d;
  logic       addr_q, addr_d;
  logic       sclk_p_q, mode_p_q;
  logic       rise, mchg;

  assign rise = sclk_i & ~sclk_p_q;
  assign mchg = mode_i ^ mode_p_q;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    addr_d = addr_q;
    vld_d  = 1'b0;
    if (mchg) begin
      cnt_d = 3'd0;
    end else if (rise) begin
      sh_d  = {dat_i, sh_q[7:1]};
      cnt_d = cnt_q + 3'd1;
      if (cnt_q == 3'd7) begin
        vld_d  = 1'b1;
        byte_d = {dat_i, sh_q[7:1]};
        addr_d = ~mode_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= 3'd0;
      sh_q     <= 8'd0;
      byte_q   <= 8'd0;
      vld_q    <= 1'b0;
      addr_q   <= 1'b0;
      sclk_p_q <= 1'b0;
      mode_p_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      byte_q   <= byte_d;
      vld_q    <= vld_d;
      addr_q   <= addr_d;
      sclk_p_q <= sclk_i;
      mode_p_q <= mode_i;
    end
  end

  assign byte_vld_o  = vld_q;
  assign byte_o      = byte_q;
  assign byte_addr_o = addr_q;

  // R1
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R5
  mode_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_p_q) |=> !byte_vld_o);
endmodule

// File: rtl/ctl3w_core.sv
module ctl3w_core
  import ctl3w_pkg::*;
#(
  parameter int         NCH    = 6,
  parameter logic [5:0] DEV_ID = 6'b000100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_i,
  input  logic                 byte_vld_i,
  input  logic [7:0]           byte_i,
  input  logic                 byte_addr_i,
  output logic [NCH*VOL_W-1:0] vol_o,
  output logic [NCH*SUB_W-1:0] sub_o,
  output logic [NCH-1:0]       mute_o,
  output logic [NCH-1:0]       pol_o,
  output logic [NCH-1:0]       sil_o,
  output logic [DE_W-1:0]      deemph_o,
  output logic [1:0]           ratio_o,
  output logic [2:0]           fmt_o,
  output logic                 quick_o,
  output logic                 power_o
);
  localparam logic [2:0] NCH_C = 3'(NCH);

  bank_e      bank_q, bank_d;
  logic       all_q, all_d;
  logic [2:0] chan_q, chan_d;
  logic [DE_W-1:0] de_q, de_d;
  logic [1:0] ratio_q, ratio_d;
  logic [2:0] fmt_q, fmt_d;
  logic       quick_q, quick_d, power_q, power_d;

  logic       data_wr, stat_wr, rst_bit;
  logic [1:0] sel;
  logic [5:0] dev_addr;

  assign sel      = byte_i[7:6];
  assign dev_addr = {DEV_ID[5:1], strap_i};
  assign data_wr  = byte_vld_i && !byte_addr_i && (bank_q == BANK_DATA);
  assign stat_wr  = byte_vld_i && !byte_addr_i && (bank_q == BANK_STAT);
  assign rst_bit  = stat_wr && !byte_i[7] && byte_i[5];

  // selection, pointer and global fields
  always_comb begin
    bank_d  = bank_q;
    all_d   = all_q;
    chan_d  = chan_q;
    de_d    = de_q;
    ratio_d = ratio_q;
    fmt_d   = fmt_q;
    quick_d = quick_q;
    power_d = power_q;
    if (byte_vld_i && byte_addr_i) begin
      if (byte_i[7:2] != dev_addr)         bank_d = BANK_NONE;
      else if (byte_i[1:0] == XFER_DATA)   bank_d = BANK_DATA;
      else if (byte_i[1:0] == XFER_STAT)   bank_d = BANK_STAT;
      else                                 bank_d = BANK_NONE;
    end
    if (data_wr && sel == SEL_CHAN) begin
      all_d  = byte_i[3];
      chan_d = byte_i[2:0];
    end
    if (data_wr && sel == SEL_FEAT && all_q) de_d = byte_i[5:3];
    if (stat_wr && !byte_i[7]) begin
      ratio_d = byte_i[4:3];
      fmt_d   = byte_i[2:0];
    end
    if (stat_wr && sel == 2'b10) begin
      quick_d = byte_i[1];
      power_d = byte_i[0];
    end
    if (rst_bit) begin
      de_d    = '0;
      quick_d = 1'b0;
      power_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= BANK_NONE;
      all_q   <= 1'b1;
      chan_q  <= 3'd0;
      de_q    <= '0;
      ratio_q <= 2'd0;
      fmt_q   <= 3'd0;
      quick_q <= 1'b0;
      power_q <= 1'b1;
    end else begin
      bank_q  <= bank_d;
      all_q   <= all_d;
      chan_q  <= chan_d;
      de_q    <= de_d;
      ratio_q <= ratio_d;
      fmt_q   <= fmt_d;
      quick_q <= quick_d;
      power_q <= power_d;
    end
  end

  // per-channel registers
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             hit;
    logic [VOL_W-1:0] vol_q, vol_d;
    logic [SUB_W-1:0] sub_q, sub_d, stg_q, stg_d;
    logic             mute_q, mute_d, pol_q, pol_d, sil_q, sil_d;

    assign hit = all_q || (chan_q == 3'(c));

    always_comb begin
      vol_d  = vol_q;
      sub_d  = sub_q;
      stg_d  = stg_q;
      mute_d = mute_q;
      pol_d  = pol_q;
      sil_d  = sil_q;
      if (data_wr && hit) begin
        unique case (sel)
          SEL_VOL: begin
            vol_d = byte_i[VOL_W-1:0];
            sub_d = stg_q;
          end
          SEL_SUB:  stg_d = byte_i[SUB_W-1:0];
          SEL_FEAT: begin
            mute_d = byte_i[2];
            sil_d  = byte_i[1];
            pol_d  = byte_i[0];
          end
          default: ;
        endcase
      end
      if (rst_bit) begin
        vol_d  = '0;
        sub_d  = '0;
        stg_d  = '0;
        mute_d = 1'b0;
        pol_d  = 1'b0;
        sil_d  = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vol_q  <= '0;
        sub_q  <= '0;
        stg_q  <= '0;
        mute_q <= 1'b0;
        pol_q  <= 1'b0;
        sil_q  <= 1'b1;
      end else begin
        vol_q  <= vol_d;
        sub_q  <= sub_d;
        stg_q  <= stg_d;
        mute_q <= mute_d;
        pol_q  <= pol_d;
        sil_q  <= sil_d;
      end
    end

    assign vol_o[c*VOL_W +: VOL_W] = vol_q;
    assign sub_o[c*SUB_W +: SUB_W] = sub_q;
    assign mute_o[c] = mute_q;
    assign pol_o[c]  = pol_q;
    assign sil_o[c]  = sil_q;
  end

  assign deemph_o = de_q;
  assign ratio_o  = ratio_q;
  assign fmt_o    = fmt_q;
  assign quick_o  = quick_q;
  assign power_o  = power_q;

  // R3
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !byte_addr_i && bank_q == BANK_NONE) |=>
      ($stable(vol_o) && $stable(mute_o) && $stable(pol_o) && $stable(sil_o) &&
       $stable(deemph_o) && $stable(ratio_o) && $stable(power_o)));

  // R6
  sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ($stable(ratio_o) && $stable(fmt_o) && $stable(quick_o) && $stable(power_o)));

  // R7
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_bit |=> (power_o && !quick_o && mute_o == '0 && pol_o == '0 && sil_o == '1 &&
                 deemph_o == '0 && vol_o == '0 && sub_o == '0));

  // R10
  bad_chan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !all_q && chan_q >= NCH_C && sel != SEL_CHAN) |=>
      ($stable(vol_o) && $stable(sub_o) && $stable(mute_o) && $stable(pol_o) && $stable(sil_o)));

  // R12
  deemph_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !all_q) |=> $stable(deemph_o));
endmodule

// File: rtl/ctl3w_ctrl.sv
module ctl3w_ctrl
  import ctl3w_pkg::*;
#(
  parameter int         NCH         = 6,
  parameter logic [5:0] DEV_ID      = 6'b000100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_clk_i,
  input  logic                 ser_mode_i,
  input  logic                 ser_dat_i,
  input  logic                 addr_strap_i,
  output logic [NCH*VOL_W-1:0] vol_o,
  output logic [NCH*SUB_W-1:0] subvol_o,
  output logic [NCH-1:0]       mute_o,
  output logic [NCH-1:0]       invert_o,
  output logic [NCH-1:0]       silence_en_o,
  output logic [DE_W-1:0]      deemph_o,
  output logic [1:0]           clk_ratio_o,
  output logic [2:0]           in_fmt_o,
  output logic                 quick_mute_o,
  output logic                 power_on_o
);
  logic [2:0] pins_s;
  logic       byte_vld, byte_addr;
  logic [7:0] byte_val;

  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_dat_i, ser_mode_i, ser_clk_i}),
    .sync_o  (pins_s)
  );

  ctl3w_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (pins_s[0]),
    .mode_i      (pins_s[1]),
    .dat_i       (pins_s[2]),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_val),
    .byte_addr_o (byte_addr)
  );

  ctl3w_core #(.NCH(NCH), .DEV_ID(DEV_ID)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_i     (addr_strap_i),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_val),
    .byte_addr_i (byte_addr),
    .vol_o       (vol_o),
    .sub_o       (subvol_o),
    .mute_o      (mute_o),
    .pol_o       (invert_o),
    .sil_o       (silence_en_o),
    .deemph_o    (deemph_o),
    .ratio_o     (clk_ratio_o),
    .fmt_o       (in_fmt_o),
    .quick_o     (quick_mute_o),
    .power_o     (power_on_o)
  );
endmodule

// File: tb/sim_ctl3w_ctrl.sv
module sim_ctl3w_ctrl;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_clk = 1'b0, s_mode = 1'b1, s_dat = 1'b0, strap = 1'b0;
  logic [NCH*6-1:0] vol;
  logic [NCH*2-1:0] subv;
  logic [NCH-1:0]   mute, inv, sil;
  logic [2:0] de, fmt;
  logic [1:0] ratio;
  logic qm, pw;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  int e_vol[NCH], e_sub[NCH], e_stg[NCH];
  bit e_mute[NCH], e_pol[NCH], e_sil[NCH];
  int e_de, e_ratio, e_fmt, bank, e_ch;
  bit e_qm, e_pw, e_all;

  always #5 clk = ~clk;

  ctl3w_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(s_clk), .ser_mode_i(s_mode),
    .ser_dat_i(s_dat), .addr_strap_i(strap), .vol_o(vol), .subvol_o(subv),
    .mute_o(mute), .invert_o(inv), .silence_en_o(sil), .deemph_o(de),
    .clk_ratio_o(ratio), .in_fmt_o(fmt), .quick_mute_o(qm), .power_on_o(pw)
  );

  task automatic defaults();
    for (int c = 0; c < NCH; c++) begin
      e_vol[c] = 0; e_sub[c] = 0; e_stg[c] = 0;
      e_mute[c] = 0; e_pol[c] = 0; e_sil[c] = 1;
    end
    e_de = 0; e_qm = 0; e_pw = 1;
  endtask

  task automatic model(bit is_addr, logic [7:0] b);
    if (is_addr) begin
      if (int'(b[7:2]) == (4 + int'(strap)))
        bank = (b[1:0] == 2'b00) ? 1 : (b[1:0] == 2'b10) ? 2 : 0;
      else bank = 0;
    end else if (bank == 1) begin
      for (int c = 0; c < NCH; c++) begin
        if (e_all || e_ch == c) begin
          case (b[7:6])
            2'b00: begin e_vol[c] = int'(b[5:0]); e_sub[c] = e_stg[c]; end
            2'b01: e_stg[c] = int'(b[1:0]);
            2'b10: begin e_mute[c] = b[2]; e_sil[c] = b[1]; e_pol[c] = b[0]; end
            default: ;
          endcase
        end
      end
      if (b[7:6] == 2'b10 && e_all) e_de = int'(b[5:3]);
      if (b[7:6] == 2'b11) begin e_all = b[3]; e_ch = int'(b[2:0]); end
    end else if (bank == 2) begin
      if (!b[7]) begin
        e_ratio = int'(b[4:3]); e_fmt = int'(b[2:0]);
        if (b[5]) defaults();
      end else if (!b[6]) begin
        e_qm = b[1]; e_pw = b[0];
      end
    end
  endtask

  task automatic send_bits(bit md, logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_mode = md; s_dat = b[i];
      repeat (6) @(negedge clk);
      s_clk = 1'b1;
      repeat (6) @(negedge clk);
      s_clk = 1'b0;
    end
  endtask

  task automatic xfer(bit is_addr, logic [7:0] b);
    send_bits(!is_addr, b, 8);
    model(is_addr, b);
    repeat (10) @(negedge clk);
  endtask

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [63:0] pv = '0, ps = '0, pm = '0, pp = '0, pz = '0;
    for (int c = 0; c < NCH; c++) begin
      pv[c*6 +: 6] = 6'(e_vol[c]);
      ps[c*2 +: 2] = 2'(e_sub[c]);
      pm[c] = e_mute[c]; pp[c] = e_pol[c]; pz[c] = e_sil[c];
    end
    chk(tag, "volume", 64'(vol), pv);
    chk(tag, "subvol", 64'(subv), ps);
    chk(tag, "mute", 64'(mute), pm);
    chk(tag, "invert", 64'(inv), pp);
    chk(tag, "silence", 64'(sil), pz);
    chk(tag, "deemph", 64'(de), 64'(e_de));
    chk(tag, "ratio", 64'(ratio), 64'(e_ratio));
    chk(tag, "format", 64'(fmt), 64'(e_fmt));
    chk(tag, "quick", 64'(qm), 64'(e_qm));
    chk(tag, "power", 64'(pw), 64'(e_pw));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    defaults(); e_ratio = 0; e_fmt = 0; bank = 0; e_all = 1; e_ch = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R13");
    // data before any address is ignored (still deselected)
    xfer(0, 8'h3F);
    check_all("R13");

    // R1 R2 R4: select data bank, then a run of data bytes
    xfer(1, 8'h10);
    xfer(0, 8'hC0);
    xfer(0, 8'h2A);
    check_all("R1");
    // R8 per-channel volume sweep
    for (int k = 0; k < NCH; k++) begin
      xfer(0, 8'(8'hC0 | k));
      xfer(0, 8'(10 + 7 * k));
      check_all("R8");
    end
    check_all("R4");

    // R11 staged sub-volume
    xfer(0, 8'hC2);
    xfer(0, 8'h43);
    check_all("R11");
    xfer(0, 8'h05);
    check_all("R11");

    // R9 all-channels writes, R12 de-emphasis with flag set
    xfer(0, 8'hC8);
    xfer(0, 8'h3F);
    check_all("R9");
    xfer(0, 8'h42);
    xfer(0, 8'h9D);
    xfer(0, 8'h21);
    check_all("R9");
    check_all("R12");

    // R12 de-emphasis refused with a single channel pointed
    xfer(0, 8'hC4);
    xfer(0, 8'h92);
    check_all("R12");

    // R10 unused channel codes
    for (int k = 6; k < 8; k++) begin
      xfer(0, 8'(8'hC0 | k));
      xfer(0, 8'h11);
      xfer(0, 8'h87);
      xfer(0, 8'h41);
      xfer(0, 8'h33);
      check_all("R10");
    end

    // R6 status sweep
    xfer(1, 8'h12);
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 8; f++) begin
        xfer(0, 8'((r << 3) | f));
        check_all("R6");
      end
    xfer(0, 8'h83);
    check_all("R6");
    xfer(0, 8'h80);
    check_all("R6");
    xfer(0, 8'h82);
    xfer(0, 8'hFF);
    check_all("R6");

    // R7 reset command keeps ratio/format from the byte
    xfer(0, 8'h2D);
    check_all("R7");

    // R3 deselecting addresses
    xfer(1, 8'h14);
    xfer(0, 8'hC8);
    xfer(0, 8'h1C);
    check_all("R3");
    xfer(1, 8'h11);
    xfer(0, 8'h1C);
    check_all("R3");
    xfer(1, 8'h13);
    xfer(0, 8'h97);
    check_all("R3");

    // R2 strap high changes the answering address
    strap = 1'b1;
    xfer(1, 8'h14);
    xfer(0, 8'hC8);
    xfer(0, 8'h27);
    check_all("R2");
    xfer(1, 8'h10);
    xfer(0, 8'h0B);
    check_all("R3");

    // R5 partial byte aborted by the mode line
    xfer(1, 8'h14);
    send_bits(1, 8'hFF, 3);
    @(negedge clk); s_mode = 1'b0;
    repeat (20) @(negedge clk);
    s_mode = 1'b1;
    repeat (20) @(negedge clk);
    xfer(0, 8'hC1);
    xfer(0, 8'h15);
    check_all("R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule